// File: doc/BRIEF.md
# Idle-Deferred Line Configuration Commit

This block sits between a host register-write port and the live line-configuration registers of an asynchronous serial transmitter. Host writes to the mode, port-value, data-format and baud-divisor settings are not applied when they arrive. Each one lands in a shadow register and raises a single pending flag. The whole shadow set is copied into the live registers in one cycle, and only when the transmitter is idle. A settings change made while a frame is on the line therefore cannot corrupt characters that are already being shifted out.

The idle condition is tracked inside the block:
- A ready pulse from the transmitter, meaning its transmit pool is writable again, sets the idle condition.
- A frame-load pulse, meaning a new frame was handed to the transmitter, clears it.

The upper divisor bits share a clock-control register with six bits that the host writes directly. A commit replaces only the top two bits of that register. The break-transmit request is one bit of the data-format setting, so starting or ending a break is also deferred until the transmitter is idle.

Top module: `cfg_commit_top`

## Requirements
- R1: After reset the live registers and the shadows hold the parameter defaults (mode 0x00, port value 0x16, data format 0x03, divisor 0x000, clock-control low bits 0x00). The pending flag is 0 and the idle flag is 1.
- R2: A host write to address 0 (mode), 1 (port value), 2 (data format), 3 (divisor bits 7:0) or 4 (divisor bits 9:8 taken from data bits 1:0) sets the pending flag at the same clock edge that stores the shadow. The live registers do not change at that edge.
- R3: While the pending flag and the idle flag are both 1, the next clock edge copies all shadows into the live registers together. If no host write arrives in that cycle, the same edge clears the pending flag. When the transmitter is already idle, a write therefore reaches the live registers one edge after it is stored.
- R4: While the idle flag is 0, pending writes are held. They are committed at the edge after the one where a ready pulse sets the idle flag.
- R5: The clock-control output is 8 bits wide. A commit writes divisor bits 9:8 into its bits 7:6. Bits 5:0 are changed only by a host write to address 5, which takes effect at once, does not set the pending flag, and leaves bits 7:6 unchanged.
- R6: Bit 6 of the data-format register is the break request. Setting or clearing it takes effect on the live output only through a commit, while the transmitter is idle.
- R7: A frame-load pulse clears the idle flag at the next edge. When a frame-load pulse and a ready pulse arrive in the same cycle, the frame-load pulse wins and the idle flag becomes 0.
- R8: A ready pulse that arrives while no commit is pending leaves every live register unchanged.
- R9: When a host write to a shadow falls in the same cycle as a commit, the commit copies the old shadow value. The shadow takes the new value and the pending flag stays 1, so the new value is committed at the next idle edge.
- R10: Host writes to addresses 6 and 7 change no shadow, no live register and not the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host write address |
| host_data | input | 8 | Host write data |
| tx_ready | input | 1 | Pulse: transmit pool writable, transmitter idle |
| frame_load | input | 1 | Pulse: a new frame was loaded for sending |
| live_mode | output | 8 | Live mode register |
| live_pval | output | 8 | Live port-value register |
| live_fmt | output | 8 | Live data-format register (bit 6 = break) |
| live_div_lo | output | 8 | Live divisor bits 7:0 |
| live_clkctl | output | 8 | Clock-control register; bits 7:6 = divisor bits 9:8 |
| cfg_pending | output | 1 | A shadow change is waiting for commit |
| tx_idle | output | 1 | Tracked transmitter-idle flag |

## Verification
Each result has a fixed arrival cycle:
- The pending flag and the clock-control low bits appear at the same edge that stores a host write.
- The idle flag follows a ready or frame-load pulse by one edge.
- A commit lands one edge after both the pending flag and the idle flag are 1.

So an idle-time write reaches the live outputs at the second edge after the strobe is first seen. A held write reaches them at the second edge after the ready pulse.

The bench drives inputs on falling edges and samples on the falling edge that follows the edge where each result is due. It also samples one edge earlier, to confirm that the live outputs have not yet moved.

// File: rtl/cfgc_pkg.sv
package cfgc_pkg;

    localparam int CFG_AW   = 3;
    localparam int CFG_DW   = 8;
    localparam int CFG_DIVW = 10;
    localparam int CFG_HI_W = CFG_DIVW - CFG_DW;
    localparam int CFG_LO_W = CFG_DW - CFG_HI_W;
    localparam int CFG_BRK_BIT = 6;

    localparam logic [CFG_AW-1:0] ADR_MODE = 3'd0;
    localparam logic [CFG_AW-1:0] ADR_PVAL = 3'd1;
    localparam logic [CFG_AW-1:0] ADR_FMT  = 3'd2;
    localparam logic [CFG_AW-1:0] ADR_DIVL = 3'd3;
    localparam logic [CFG_AW-1:0] ADR_DIVH = 3'd4;
    localparam logic [CFG_AW-1:0] ADR_CCTL = 3'd5;

    typedef struct packed {
        logic [CFG_DW-1:0]   mode;
        logic [CFG_DW-1:0]   pval;
        logic [CFG_DW-1:0]   fmt;
        logic [CFG_DIVW-1:0] div;
    } cfg_set_t;

    typedef struct packed {
        cfg_set_t set;
        logic     pending;
    } shadow_st_t;

    typedef struct packed {
        logic [CFG_DW-1:0] mode;
        logic [CFG_DW-1:0] pval;
        logic [CFG_DW-1:0] fmt;
        logic [CFG_DW-1:0] div_lo;
        logic [CFG_DW-1:0] clkctl;
    } live_st_t;

endpackage

// File: rtl/cfgc_shadow_bank.sv
module cfgc_shadow_bank
    import cfgc_pkg::*;
#(
    parameter cfg_set_t RST_SET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] wr_addr,
    input  logic [CFG_DW-1:0] wr_data,
    input  logic              commit,
    output cfg_set_t          shadow_q,
    output logic              pending_q
);

    shadow_st_t st_d, st_q;
    logic       cfg_hit;

    always_comb begin
        st_d    = st_q;
        cfg_hit = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                ADR_MODE: begin st_d.set.mode = wr_data; cfg_hit = 1'b1; end
                ADR_PVAL: begin st_d.set.pval = wr_data; cfg_hit = 1'b1; end
                ADR_FMT:  begin st_d.set.fmt  = wr_data; cfg_hit = 1'b1; end
                ADR_DIVL: begin st_d.set.div[CFG_DW-1:0] = wr_data; cfg_hit = 1'b1; end
                ADR_DIVH: begin
                    st_d.set.div[CFG_DIVW-1:CFG_DW] = wr_data[CFG_HI_W-1:0];
                    cfg_hit = 1'b1;
                end
                default: cfg_hit = 1'b0;
            endcase
        end
        // a fresh write outranks the clear from a commit in the same cycle
        if (cfg_hit)
            st_d.pending = 1'b1;
        else if (commit)
            st_d.pending = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.set     <= RST_SET;
            st_q.pending <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_q  = st_q.set;
    assign pending_q = st_q.pending;

    // R2: a configuration write raises the pending flag
    a_r2_write_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr <= ADR_DIVH) |=> pending_q);

    // R9: a write in the commit cycle wins in the shadow and keeps pending
    a_r9_write_beats_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_en && wr_addr == ADR_MODE) |=>
            (pending_q && shadow_q.mode == $past(wr_data)));

    // R10: writes to unused addresses leave the shadows alone
    a_r10_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADR_CCTL) |=> $stable(shadow_q));

endmodule

// File: rtl/cfgc_idle_tracker.sv
module cfgc_idle_tracker #(
    parameter logic RST_IDLE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_ready,
    input  logic frame_load,
    output logic idle_q
);

    typedef struct packed {
        logic idle;
    } idle_st_t;

    idle_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_load)
            st_d.idle = 1'b0;
        else if (tx_ready)
            st_d.idle = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q.idle <= RST_IDLE;
        else
            st_q <= st_d;
    end

    assign idle_q = st_q.idle;

    // R7: a frame load always drops the idle flag
    a_r7_load_clears_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> !idle_q);

    // R4: a ready pulse alone raises the idle flag
    a_r4_ready_sets_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !frame_load) |=> idle_q);

endmodule

// File: rtl/cfgc_live_bank.sv
module cfgc_live_bank
    import cfgc_pkg::*;
#(
    parameter live_st_t RST_LIVE = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                commit,
    input  cfg_set_t            shadow,
    input  logic                cctl_wr,
    input  logic [CFG_LO_W-1:0] cctl_data,
    output live_st_t            live_q
);

    live_st_t st_d, st_q;
    logic [CFG_HI_W-1:0] cctl_hi_d;
    logic [CFG_LO_W-1:0] cctl_lo_d;

    always_comb begin
        st_d      = st_q;
        cctl_hi_d = st_q.clkctl[CFG_DW-1:CFG_LO_W];
        cctl_lo_d = st_q.clkctl[CFG_LO_W-1:0];
        if (commit) begin
            st_d.mode   = shadow.mode;
            st_d.pval   = shadow.pval;
            st_d.fmt    = shadow.fmt;
            st_d.div_lo = shadow.div[CFG_DW-1:0];
            cctl_hi_d   = shadow.div[CFG_DIVW-1:CFG_DW];
        end
        if (cctl_wr)
            cctl_lo_d = cctl_data;
        // read-modify-write: top bits from the divisor, low bits kept
        st_d.clkctl = {cctl_hi_d, cctl_lo_d};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= RST_LIVE;
        else
            st_q <= st_d;
    end

    assign live_q = st_q;

    // R3: a commit copies every shadow field together
    a_r3_commit_copies: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_q.mode == $past(shadow.mode) &&
                    live_q.pval == $past(shadow.pval) &&
                    live_q.fmt  == $past(shadow.fmt)  &&
                    live_q.div_lo == $past(shadow.div[CFG_DW-1:0])));

    // R5: commit fills the clock-control top bits, low bits preserved
    a_r5_cctl_rmw: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !cctl_wr) |=>
            (live_q.clkctl[CFG_DW-1:CFG_LO_W] == $past(shadow.div[CFG_DIVW-1:CFG_DW]) &&
             live_q.clkctl[CFG_LO_W-1:0] == $past(live_q.clkctl[CFG_LO_W-1:0])));

    // R8: without a commit the deferred live registers hold
    a_r8_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(live_q.mode) && $stable(live_q.pval) &&
                     $stable(live_q.fmt) && $stable(live_q.div_lo)));

endmodule

// File: rtl/cfg_commit_top.sv
module cfg_commit_top
    import cfgc_pkg::*;
#(
    parameter logic [CFG_DW-1:0]   MODE_DEF    = 8'h00,
    parameter logic [CFG_DW-1:0]   PVAL_DEF    = 8'h16,
    parameter logic [CFG_DW-1:0]   FMT_DEF     = 8'h03,
    parameter logic [CFG_DIVW-1:0] DIV_DEF     = 10'h000,
    parameter logic [CFG_LO_W-1:0] CCTL_LO_DEF = 6'h00,
    parameter logic                IDLE_DEF    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [CFG_AW-1:0] host_addr,
    input  logic [CFG_DW-1:0] host_data,
    input  logic              tx_ready,
    input  logic              frame_load,
    output logic [CFG_DW-1:0] live_mode,
    output logic [CFG_DW-1:0] live_pval,
    output logic [CFG_DW-1:0] live_fmt,
    output logic [CFG_DW-1:0] live_div_lo,
    output logic [CFG_DW-1:0] live_clkctl,
    output logic              cfg_pending,
    output logic              tx_idle
);

    localparam cfg_set_t RST_SET = '{mode: MODE_DEF, pval: PVAL_DEF,
                                     fmt: FMT_DEF, div: DIV_DEF};
    localparam live_st_t RST_LIVE = '{mode: MODE_DEF, pval: PVAL_DEF,
                                      fmt: FMT_DEF, div_lo: DIV_DEF[CFG_DW-1:0],
                                      clkctl: {DIV_DEF[CFG_DIVW-1:CFG_DW], CCTL_LO_DEF}};

    cfg_set_t shadow;
    live_st_t live;
    logic     pending, idle, commit, cctl_wr;

    assign commit  = pending && idle;
    assign cctl_wr = host_wr && host_addr == ADR_CCTL;

    cfgc_shadow_bank #(.RST_SET(RST_SET)) u_shadow (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr), .wr_addr(host_addr), .wr_data(host_data),
        .commit(commit), .shadow_q(shadow), .pending_q(pending)
    );

    cfgc_idle_tracker #(.RST_IDLE(IDLE_DEF)) u_idle (
        .clk(clk), .rst_n(rst_n),
        .tx_ready(tx_ready), .frame_load(frame_load), .idle_q(idle)
    );

    cfgc_live_bank #(.RST_LIVE(RST_LIVE)) u_live (
        .clk(clk), .rst_n(rst_n), .commit(commit), .shadow(shadow),
        .cctl_wr(cctl_wr), .cctl_data(host_data[CFG_LO_W-1:0]), .live_q(live)
    );

    assign live_mode   = live.mode;
    assign live_pval   = live.pval;
    assign live_fmt    = live.fmt;
    assign live_div_lo = live.div_lo;
    assign live_clkctl = live.clkctl;
    assign cfg_pending = pending;
    assign tx_idle     = idle;

    // R3: a commit with no new write empties the pending flag
    a_r3_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_pending && tx_idle && !host_wr) |=> !cfg_pending);

    // R6: the break bit on the line moves only while idle with work pending
    a_r6_break_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_pending && tx_idle) |=> $stable(live_fmt[CFG_BRK_BIT]));

    // R4: nothing is committed while the transmitter is busy
    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_idle |=> ($stable(live_mode) && $stable(live_div_lo)));

endmodule

// File: tb/cfg_commit_top_tb.sv
module cfg_commit_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_data = '0;
    logic       tx_ready = 1'b0;
    logic       frame_load = 1'b0;
    logic [7:0] live_mode, live_pval, live_fmt, live_div_lo, live_clkctl;
    logic       cfg_pending, tx_idle;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cfg_commit_top u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .tx_ready(tx_ready), .frame_load(frame_load),
        .live_mode(live_mode), .live_pval(live_pval), .live_fmt(live_fmt),
        .live_div_lo(live_div_lo), .live_clkctl(live_clkctl),
        .cfg_pending(cfg_pending), .tx_idle(tx_idle)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // one-cycle host write; returns at the falling edge after the storing edge
    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse(input logic rdy, input logic ld);
        @(negedge clk);
        tx_ready = rdy; frame_load = ld;
        @(negedge clk);
        tx_ready = 1'b0; frame_load = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 mode",    live_mode,   8'h00);
        chk("R1 pval",    live_pval,   8'h16);
        chk("R1 fmt",     live_fmt,    8'h03);
        chk("R1 div_lo",  live_div_lo, 8'h00);
        chk("R1 clkctl",  live_clkctl, 8'h00);
        chk("R1 pending", cfg_pending, 1'b0);
        chk("R1 idle",    tx_idle,     1'b1);
    endtask

    task automatic t_idle_commit();
        host_write(3'd0, 8'hA5);
        chk("R2 pending set", cfg_pending, 1'b1);
        chk("R2 live mode not yet", live_mode, 8'h00);
        step();
        chk("R3 mode committed", live_mode, 8'hA5);
        chk("R3 pending cleared", cfg_pending, 1'b0);
        host_write(3'd1, 8'h5C);
        step();
        chk("R3 pval committed", live_pval, 8'h5C);
    endtask

    task automatic t_deferred();
        pulse(1'b0, 1'b1);
        chk("R7 load clears idle", tx_idle, 1'b0);
        host_write(3'd2, 8'h43);
        host_write(3'd3, 8'h34);
        host_write(3'd4, 8'h02);
        step(); step();
        chk("R4 held while busy pending", cfg_pending, 1'b1);
        chk("R6 break held while busy", live_fmt, 8'h03);
        chk("R4 div held while busy", live_div_lo, 8'h00);
        pulse(1'b1, 1'b0);
        chk("R4 idle set by ready", tx_idle, 1'b1);
        chk("R4 not committed at idle edge", live_div_lo, 8'h00);
        step();
        chk("R6 break applied at idle", live_fmt, 8'h43);
        chk("R4 div lo applied", live_div_lo, 8'h34);
        chk("R5 div hi in clkctl top", live_clkctl, 8'h80);
        chk("R3 pending clear after commit", cfg_pending, 1'b0);
    endtask

    task automatic t_clkctl();
        host_write(3'd5, 8'h2A);
        chk("R5 low bits immediate", live_clkctl, 8'hAA);
        chk("R5 low write not pending", cfg_pending, 1'b0);
        host_write(3'd4, 8'h01);
        step();
        chk("R5 rmw keeps low bits", live_clkctl, 8'h6A);
        pulse(1'b0, 1'b1);
        host_write(3'd2, 8'h03);
        step();
        chk("R6 break removal deferred", live_fmt, 8'h43);
        pulse(1'b1, 1'b0);
        step();
        chk("R6 break removed at idle", live_fmt, 8'h03);
    endtask

    task automatic t_no_pending();
        pulse(1'b1, 1'b0);
        step();
        chk("R8 mode unchanged", live_mode, 8'hA5);
        chk("R8 fmt unchanged", live_fmt, 8'h03);
        chk("R8 clkctl unchanged", live_clkctl, 8'h6A);
    endtask

    task automatic t_race();
        @(negedge clk);
        host_wr = 1'b1; host_addr = 3'd0; host_data = 8'h11;
        @(negedge clk);
        host_data = 8'h22;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R9 old value committed", live_mode, 8'h11);
        chk("R9 pending kept", cfg_pending, 1'b1);
        step();
        chk("R9 new value committed next", live_mode, 8'h22);
        chk("R9 pending cleared", cfg_pending, 1'b0);
    endtask

    task automatic t_load_vs_ready();
        pulse(1'b1, 1'b1);
        chk("R7 load beats ready", tx_idle, 1'b0);
        pulse(1'b1, 1'b0);
        chk("R7 ready restores idle", tx_idle, 1'b1);
    endtask

    task automatic t_unused();
        host_write(3'd6, 8'hFF);
        chk("R10 addr6 no pending", cfg_pending, 1'b0);
        host_write(3'd7, 8'hEE);
        step();
        chk("R10 addr7 no pending", cfg_pending, 1'b0);
        chk("R10 mode unchanged", live_mode, 8'h22);
        chk("R10 clkctl unchanged", live_clkctl, 8'h6A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_commit();
        t_deferred();
        t_clkctl();
        t_no_pending();
        t_race();
        t_load_vs_ready();
        t_unused();
        step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule